// File: doc/BRIEF.md
# T1 Line Density and LOS Monitor

This block watches the raw receive bit stream of a T1 line, one bit for each strobe on `bit_en`, and raises three indications. The first is a pulse-density violation indication that inverts once for each new violation episode. The second is an all-ones (blue) alarm, judged once per fixed window of millisecond ticks. The third is a digital loss-of-signal flag. That flag sets on a long run of zeros and clears only after a whole measurement window shows enough pulse density.

The density rule depends on a mode input. When zero substitution is in use on the line, only a short zero run counts as a violation. Without zero substitution, a longer zero run counts, and so does a family of sliding windows. Each window of 8(N+1) bits must hold at least N ones, for every N up to a parameterised limit. The windows share one bit history register, and each window keeps its own running ones count. The millisecond tick comes from elsewhere in the receiver. The blue-alarm window and the loss-of-signal window are back-to-back intervals counted from reset.

Top module: `t1_density_los_mon`

## Requirements
- R1: With `b8zs_en`=1, a run of 8 consecutive received zeros is a violation. A run of 7 zeros is not.
- R2: With `b8zs_en`=0, a run of 16 consecutive zeros is a violation. A run of 15 zeros that follows a long stream of ones is not.
- R3: With `b8zs_en`=0, any window of the last 8(N+1) received bits that holds fewer than N ones is a violation, for each N from 1 to MAX_N. A window is judged only once at least 8(N+1) bits have arrived since reset. A repeating pattern of one 1 followed by seven 0s never violates. A repeating pattern of one 1 followed by fourteen 0s does violate.
- R4: `pdv_toggle` inverts exactly once at the start of each violation episode, when the violation condition goes from false to true. It does not invert again while the condition stays true. It changes at most once per bit time.
- R5: `blue_alarm` is updated only at the end of each window of BLUE_MS ticks. At that point it becomes 1 if fewer than 6 zeros arrived in the window, and 0 otherwise.
- R6: `los_alarm` becomes 1 after 192 consecutive received zeros and not after 191.
- R7: `los_alarm` clears only at the end of a window of LOS_CLR_MS ticks, and only when ones×8 exceeds the number of bits received in that window and the zero run is below 192. A window with exactly 12.5% ones leaves `los_alarm` set.
- R8: After reset, `pdv_toggle`, `blue_alarm` and `los_alarm` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bit_en | input | 1 | One-cycle strobe marking a valid received bit |
| rx_bit | input | 1 | Received line bit, sampled when `bit_en` is 1 |
| b8zs_en | input | 1 | 1 selects the zero-substitution line rule |
| ms_tick | input | 1 | One-cycle pulse each millisecond |
| pdv_toggle | output | 1 | Inverts once per pulse-density violation episode |
| blue_alarm | output | 1 | All-ones alarm, updated at the end of each window |
| los_alarm | output | 1 | Digital loss of signal |

## Verification
The bench keeps the full density rule at its default size: 23 window lengths over a 192-bit history. This lets the long windows fill, and shows that sparse patterns with no long zero run still violate. The loss-of-signal clear window is reduced to LOS_CLR_MS=4 ticks. This brings several whole clear windows, including the exact 12.5% boundary, within a few hundred bits. The blue window keeps its 3-tick length, so the set and clear conditions on either side of 6 zeros can be hit in consecutive windows.

// File: rtl/t1dm_pkg.sv
package t1dm_pkg;
    // Length in bits of the density window that must hold at least n ones.
    function automatic int win_len(input int n);
        return 8 * (n + 1);
    endfunction
endpackage

// File: rtl/t1dm_density.sv
module t1dm_density #(
    parameter int MAX_N = 23
) (
    input  logic clk,
    input  logic rst_n,
    input  logic bit_en,
    input  logic rx_bit,
    output logic fail
);
    localparam int HIST = t1dm_pkg::win_len(MAX_N);
    localparam int FW   = $clog2(HIST + 1);
    localparam int CW   = FW;

    typedef struct packed {
        logic [HIST-1:0]           hist;   // bit 0 = newest
        logic [FW-1:0]             fill;
        logic [MAX_N:1][CW-1:0]    cnt;
    } dens_t;

    dens_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        if (bit_en) begin
            s_d.hist = {s_q.hist[HIST-2:0], rx_bit};
            if (s_q.fill != FW'(HIST)) s_d.fill = s_q.fill + 1'b1;
            for (int n = 1; n <= MAX_N; n++) begin
                // the bit that drops out of window n is at position len-1
                s_d.cnt[n] = s_q.cnt[n] + CW'(rx_bit)
                           - CW'(s_q.hist[t1dm_pkg::win_len(n) - 1]);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    logic [MAX_N:1] fail_v;
    for (genvar g = 1; g <= MAX_N; g++) begin : g_win
        assign fail_v[g] = (s_q.fill >= FW'(t1dm_pkg::win_len(g)))
                        && (s_q.cnt[g] < CW'(g));

        // R3: a running count never exceeds its window length
        p_cnt_bound_r3: assert property (@(posedge clk) disable iff (!rst_n)
            s_q.cnt[g] <= CW'(t1dm_pkg::win_len(g)));
    end

    assign fail = |fail_v;
endmodule

// File: rtl/t1dm_blue.sv
module t1dm_blue #(
    parameter int BLUE_MS  = 3,
    parameter int MIN_ZERO = 6
) (
    input  logic clk,
    input  logic rst_n,
    input  logic bit_en,
    input  logic rx_bit,
    input  logic ms_tick,
    output logic blue
);
    localparam int MW = $clog2(BLUE_MS + 1);
    localparam int ZW = $clog2(MIN_ZERO + 1);

    typedef struct packed {
        logic [MW-1:0] ms;
        logic [ZW-1:0] zeros;
        logic          blue;
    } blue_t;

    blue_t s_d, s_q;
    logic [ZW-1:0] z_n;

    always_comb begin
        s_d = s_q;
        z_n = s_q.zeros;
        if (bit_en && !rx_bit && s_q.zeros < ZW'(MIN_ZERO)) z_n = s_q.zeros + 1'b1;
        s_d.zeros = z_n;
        if (ms_tick) begin
            if (s_q.ms == MW'(BLUE_MS - 1)) begin
                s_d.blue  = (z_n < ZW'(MIN_ZERO));
                s_d.ms    = '0;
                s_d.zeros = '0;
            end else begin
                s_d.ms = s_q.ms + 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign blue = s_q.blue;

    // R5: the alarm only moves on a window-closing tick
    p_blue_on_tick_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(s_q.blue) |-> $past(ms_tick));
endmodule

// File: rtl/t1dm_los.sv
module t1dm_los #(
    parameter int LOS_CLR_MS = 250,
    parameter int CNT_W      = 20
) (
    input  logic clk,
    input  logic rst_n,
    input  logic bit_en,
    input  logic rx_bit,
    input  logic ms_tick,
    input  logic zrun_hit,
    output logic los
);
    localparam int MW = $clog2(LOS_CLR_MS + 1);

    typedef struct packed {
        logic [MW-1:0]    ms;
        logic [CNT_W-1:0] bits;
        logic [CNT_W-1:0] ones;
        logic             los;
    } los_t;

    los_t s_d, s_q;
    logic [CNT_W-1:0] b_n, o_n;
    logic             dense;

    always_comb begin
        s_d   = s_q;
        b_n   = s_q.bits + CNT_W'(bit_en);
        o_n   = s_q.ones + CNT_W'(bit_en & rx_bit);
        dense = {o_n, 3'b000} > {3'b000, b_n};
        s_d.bits = b_n;
        s_d.ones = o_n;
        if (ms_tick) begin
            if (s_q.ms == MW'(LOS_CLR_MS - 1)) begin
                if (dense) s_d.los = 1'b0;
                s_d.ms   = '0;
                s_d.bits = '0;
                s_d.ones = '0;
            end else begin
                s_d.ms = s_q.ms + 1'b1;
            end
        end
        if (zrun_hit) s_d.los = 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign los = s_q.los;

    // R7: clearing happens only on a tick
    p_los_clear_tick_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(s_q.los) |-> $past(ms_tick));
endmodule

// File: rtl/t1_density_los_mon.sv
module t1_density_los_mon #(
    parameter int MAX_N          = 23,
    parameter int B8ZS_RUN       = 8,
    parameter int AMI_RUN        = 16,
    parameter int LOS_ZEROS      = 192,
    parameter int BLUE_MS        = 3,
    parameter int BLUE_MIN_ZEROS = 6,
    parameter int LOS_CLR_MS     = 250,
    parameter int CNT_W          = 20
) (
    input  logic clk,
    input  logic rst_n,
    input  logic bit_en,
    input  logic rx_bit,
    input  logic b8zs_en,
    input  logic ms_tick,
    output logic pdv_toggle,
    output logic blue_alarm,
    output logic los_alarm
);
    localparam int RW = $clog2(LOS_ZEROS + 1);

    typedef struct packed {
        logic [RW-1:0] run;
        logic          vprev;
        logic          pdv;
    } top_t;

    top_t s_d, s_q;
    logic dens_fail, viol;

    t1dm_density #(.MAX_N(MAX_N)) u_dens (
        .clk(clk), .rst_n(rst_n), .bit_en(bit_en), .rx_bit(rx_bit), .fail(dens_fail)
    );

    t1dm_blue #(.BLUE_MS(BLUE_MS), .MIN_ZERO(BLUE_MIN_ZEROS)) u_blue (
        .clk(clk), .rst_n(rst_n), .bit_en(bit_en), .rx_bit(rx_bit),
        .ms_tick(ms_tick), .blue(blue_alarm)
    );

    t1dm_los #(.LOS_CLR_MS(LOS_CLR_MS), .CNT_W(CNT_W)) u_los (
        .clk(clk), .rst_n(rst_n), .bit_en(bit_en), .rx_bit(rx_bit),
        .ms_tick(ms_tick), .zrun_hit(s_q.run >= RW'(LOS_ZEROS)), .los(los_alarm)
    );

    always_comb begin
        s_d = s_q;
        if (bit_en) begin
            if (rx_bit)                        s_d.run = '0;
            else if (s_q.run != RW'(LOS_ZEROS)) s_d.run = s_q.run + 1'b1;
        end
        viol = b8zs_en ? (s_q.run >= RW'(B8ZS_RUN))
                       : ((s_q.run >= RW'(AMI_RUN)) || dens_fail);
        s_d.vprev = viol;
        if (viol && !s_q.vprev) s_d.pdv = ~s_q.pdv;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign pdv_toggle = s_q.pdv;

    // R4: two inversions never come on consecutive cycles
    p_pdv_single_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(pdv_toggle) |=> $stable(pdv_toggle));

    // R4: a fresh violation produces an inversion
    p_pdv_on_event_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(viol) |=> !$stable(pdv_toggle));

    // R6: a long zero run forces loss of signal on the next cycle
    p_los_set_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.run >= RW'(LOS_ZEROS)) |=> los_alarm);
endmodule

// File: tb/t1_density_los_mon_bench.sv
module t1_density_los_mon_bench;
    localparam int CLR_MS = 4;
    localparam int HMAX   = 192;

    logic clk = 1'b0, rst_n = 1'b0, bit_en = 1'b0, rx_bit = 1'b0;
    logic b8zs_en = 1'b0, ms_tick = 1'b0;
    logic pdv_toggle, blue_alarm, los_alarm;

    t1_density_los_mon #(.LOS_CLR_MS(CLR_MS)) u_t1_density_los_mon (
        .clk(clk), .rst_n(rst_n), .bit_en(bit_en), .rx_bit(rx_bit),
        .b8zs_en(b8zs_en), .ms_tick(ms_tick), .pdv_toggle(pdv_toggle),
        .blue_alarm(blue_alarm), .los_alarm(los_alarm)
    );

    always #5 clk = ~clk;

    int n_chk = 0, n_err = 0;
    bit done = 0;

    // reference model state
    int h[HMAX];
    int fill, run, m_ms_b, m_zero, m_ms_l, m_bits, m_ones;
    bit m_vp, m_pdv, m_blue, m_los;
    int pdv_changes;

    task automatic chk(input string req, input string what, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_err++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic reset_dut(input bit mode);
        @(negedge clk);
        rst_n = 0; bit_en = 0; ms_tick = 0; b8zs_en = mode;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1;
        for (int i = 0; i < HMAX; i++) h[i] = 0;
        fill = 0; run = 0; m_ms_b = 0; m_zero = 0; m_ms_l = 0; m_bits = 0; m_ones = 0;
        m_vp = 0; m_pdv = 0; m_blue = 0; m_los = 0; pdv_changes = 0;
    endtask

    function automatic bit model_viol();
        bit d = 0;
        if (b8zs_en) return run >= 8;
        for (int n = 1; n <= 23; n++) begin
            int len = 8 * (n + 1);
            int ones = 0;
            if (fill >= len) begin
                for (int i = 0; i < len; i++) ones += h[i];
                if (ones < n) d = 1;
            end
        end
        return (run >= 16) || d;
    endfunction

    task automatic cmp_all(input string req);
        chk(req, "pdv_toggle", int'(pdv_toggle), int'(m_pdv));
        chk(req, "blue_alarm", int'(blue_alarm), int'(m_blue));
        chk(req, "los_alarm", int'(los_alarm), int'(m_los));
    endtask

    task automatic send_bit(input bit b, input string req);
        bit v;
        bit old = pdv_toggle;
        @(negedge clk); bit_en = 1; rx_bit = b;
        @(negedge clk); bit_en = 0;
        @(negedge clk);
        for (int i = HMAX - 1; i > 0; i--) h[i] = h[i-1];
        h[0] = b;
        if (fill < HMAX) fill++;
        run = b ? 0 : (run < 192 ? run + 1 : run);
        v = model_viol();
        if (v && !m_vp) m_pdv = ~m_pdv;
        m_vp = v;
        if (!b) m_zero++;
        m_bits++; m_ones += b;
        if (run >= 192) m_los = 1;
        if (pdv_toggle != old) pdv_changes++;
        cmp_all(req);
    endtask

    task automatic send_rep(input bit b, input int cnt, input string req);
        for (int i = 0; i < cnt; i++) send_bit(b, req);
    endtask

    task automatic tick(input string req);
        @(negedge clk); ms_tick = 1;
        @(negedge clk); ms_tick = 0;
        @(negedge clk);
        m_ms_b++;
        if (m_ms_b == 3) begin m_blue = (m_zero < 6); m_ms_b = 0; m_zero = 0; end
        m_ms_l++;
        if (m_ms_l == CLR_MS) begin
            if (run < 192 && m_ones * 8 > m_bits) m_los = 0;
            m_ms_l = 0; m_bits = 0; m_ones = 0;
        end
        cmp_all(req);
    endtask

    task automatic t_reset();
        reset_dut(0);
        chk("R8", "pdv after reset", int'(pdv_toggle), 0);
        chk("R8", "blue after reset", int'(blue_alarm), 0);
        chk("R8", "los after reset", int'(los_alarm), 0);
    endtask

    task automatic t_b8zs_run();
        reset_dut(1);
        send_bit(1, "R1");
        send_rep(0, 7, "R1");
        chk("R1", "7 zeros no toggle", int'(pdv_toggle), 0);
        send_bit(0, "R1");
        chk("R1", "8th zero toggles", int'(pdv_toggle), 1);
        send_rep(0, 12, "R4");
        chk("R4", "long run toggles once", int'(pdv_toggle), 1);
        send_bit(1, "R4");
        send_rep(0, 8, "R4");
        chk("R4", "new episode toggles again", int'(pdv_toggle), 0);
    endtask

    task automatic t_ami_run();
        reset_dut(0);
        send_rep(1, 200, "R2");
        send_rep(0, 15, "R2");
        chk("R2", "15 zeros no toggle", int'(pdv_toggle), 0);
        send_bit(0, "R2");
        chk("R2", "16th zero toggles", int'(pdv_toggle), 1);
        send_rep(0, 5, "R4");
        chk("R4", "one toggle per run", int'(pdv_toggle), 1);
        send_rep(1, 200, "R2");
        send_rep(0, 16, "R2");
        chk("R2", "second run toggles back", int'(pdv_toggle), 0);
    endtask

    task automatic t_density();
        reset_dut(0);
        send_rep(1, 200, "R3");
        for (int k = 0; k < 40; k++) begin
            send_bit(1, "R3");
            send_rep(0, 7, "R3");
        end
        chk("R3", "1-in-8 pattern never violates", pdv_changes, 0);
        for (int k = 0; k < 14; k++) begin
            send_bit(1, "R3");
            send_rep(0, 14, "R3");
        end
        chk("R3", "1-in-15 pattern violates", int'(pdv_changes > 0), 1);
    endtask

    task automatic t_blue();
        reset_dut(0);
        send_rep(1, 10, "R5");
        tick("R5"); tick("R5");
        send_rep(0, 5, "R5");
        send_rep(1, 4, "R5");
        chk("R5", "blue before window end", int'(blue_alarm), 0);
        tick("R5");
        chk("R5", "5 zeros sets blue", int'(blue_alarm), 1);
        send_rep(1, 3, "R5");
        for (int i = 0; i < 6; i++) begin send_bit(0, "R5"); send_bit(1, "R5"); end
        tick("R5"); tick("R5");
        chk("R5", "blue holds mid window", int'(blue_alarm), 1);
        tick("R5");
        chk("R5", "6 zeros clears blue", int'(blue_alarm), 0);
    endtask

    task automatic t_los();
        reset_dut(0);
        send_rep(0, 191, "R6");
        chk("R6", "191 zeros no los", int'(los_alarm), 0);
        send_bit(0, "R6");
        chk("R6", "192 zeros sets los", int'(los_alarm), 1);
        for (int i = 0; i < CLR_MS; i++) tick("R7");
        chk("R7", "empty window keeps los", int'(los_alarm), 1);
        for (int k = 0; k < 4; k++) begin send_bit(1, "R7"); send_rep(0, 7, "R7"); end
        for (int i = 0; i < CLR_MS; i++) tick("R7");
        chk("R7", "exact 12.5% keeps los", int'(los_alarm), 1);
        for (int k = 0; k < 4; k++) begin send_bit(1, "R7"); send_rep(0, 6, "R7"); end
        for (int i = 0; i < CLR_MS - 1; i++) tick("R7");
        chk("R7", "no clear before window end", int'(los_alarm), 1);
        tick("R7");
        chk("R7", "dense window clears los", int'(los_alarm), 0);
    endtask

    initial begin
        t_reset();
        t_b8zs_run();
        t_ami_run();
        t_density();
        t_blue();
        t_los();
        if (!done) begin
            done = 1;
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            done = 1;
            n_chk++; n_err++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    end
endmodule